// File: doc/BRIEF.md
# Multi-Bus Interrupt Status Aggregator

This block holds the interrupt state for a group of two-wire serial bus engines that share one interrupt line toward the processor. Each bus has a status register and an enable register. The engines report events as one-cycle pulses. A pulse latches a status bit, and software clears that bit by writing a 1 to its position. A controller-level summary register keeps one bit per bus. The shared interrupt output is the OR of those summary bits.

A bus's summary bit is raised when an event arrives whose enable bit is set. It is dropped only by a status write that leaves every stored event bit of that bus at zero. A status write that clears only some of the pending bits therefore keeps the interrupt asserted, so no pending event is lost while software services the others. Two further status bits report, as live levels, which slave address matched and whether a slave address receive is pending.

Software reaches the registers through a word-addressed bus. The address is split as {slot, select}. For bus b, `{b,0}` is the enable register and `{b,1}` is the status register. The slot with all bits set, with select 0, is the summary register. Writes take effect on the clock edge, and reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable, status and summary register reads zero and `irq_o` is low.
- R2: A pulse on event bit i of bus b sets status bit i of that bus when i is in the implemented set {0..7, 13, 14, 15}. Bits 8 to 12 can never be set and always read zero.
- R3: A write to an enable register keeps only write-data bits [14:0]. Bits 31 to 15 of an enable read are zero.
- R4: A status write clears each status bit in [14:0] whose write-data bit is 1 and leaves all other bits unchanged. Bit 15 (slave inactive timeout) cannot be cleared by a write.
- R5: An event pulse on a bit whose enable bit is set sets that bus's summary bit (summary bit index = bus number) on the same edge, and `irq_o` goes high.
- R6: A status write that leaves any stored event bit [15:0] of that bus set keeps that bus's summary bit and `irq_o` unchanged.
- R7: A status write that leaves all stored event bits [15:0] of a bus at zero clears that bus's summary bit on the same edge. A summary bit never falls on any other event.
- R8: When an event pulse and a write-1-to-clear hit the same status bit on the same edge, the bit ends up set, and the summary bit stays set if the bit is enabled.
- R9: Status bit 31 follows the bus's slave-address-select input (0 = first address, 1 = second). Bit 30 follows its slave-receive-pending input. Bits [29:16] read zero. Bits 31 and 30 do not take part in the all-clear test of R7.
- R10: An event pulse on a bit whose enable bit is clear sets the status bit but not the summary bit, and leaves `irq_o` unchanged.
- R11: `irq_o` is high exactly when at least one summary bit is set. The summary register reads back with bit b for bus b and zeros above.
- R12: Reads of an address outside the map (an unused slot, or the summary slot with select 1) return zero, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | SLOT_W+1 | Word address {slot, select} |
| wdata_i | input | 32 | Write data |
| evt_i | input | NUM_BUS*16 | Event pulses, 16 per bus, bus b at [16b+15:16b] |
| slv_sel_i | input | NUM_BUS | Matched slave address select, per bus |
| slv_pend_i | input | NUM_BUS | Slave address receive pending, per bus |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The bench builds the block with four buses and the default event mask. With four buses the summary slot sits at slot 7, and slots 4 to 6 are unused, so reads of addresses outside the map can be tested. Four buses also let two summary bits be set together and then cleared one at a time, which shows the interrupt staying high until the last bus is serviced. The default mask makes bit 15 settable but not clearable, so the bench can reach the case where a stuck bit holds a summary bit through a clear of every enabled bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   localparam int DATA_W    = 32;
   localparam int EVT_W     = 16;
   localparam int W1C_W     = 15;
   localparam int CTRL_W    = 15;
   localparam int SEL_BIT   = 31;
   localparam int PEND_BIT  = 30;

   typedef enum logic {
      REG_ENABLE = 1'b0,
      REG_STATUS = 1'b1
   } reg_sel_e;

endpackage

// File: rtl/irq_bus_slice.sv
module irq_bus_slice
   import irq_agg_pkg::*;
#(
   parameter int              BUS_ID   = 0,
   parameter int              SLOT_W   = 3,
   parameter logic [EVT_W-1:0] EVT_MASK = 16'hE0FF
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_en_i,
   input  logic [SLOT_W-1:0]    wr_slot_i,
   input  reg_sel_e             wr_sel_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic [EVT_W-1:0]     evt_i,
   input  logic                 slv_sel_i,
   input  logic                 slv_pend_i,
   output logic [CTRL_W-1:0]    enable_o,
   output logic [DATA_W-1:0]    status_word_o,
   output logic                 summary_o
);

   localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(BUS_ID);

   logic                 hit_slot;
   logic                 wr_enable;
   logic                 wr_status;
   logic [EVT_W-1:0]     set_vec;
   logic [EVT_W-1:0]     clr_vec;
   logic [EVT_W-1:0]     stat_d;
   logic [EVT_W-1:0]     stat_q;
   logic [CTRL_W-1:0]    enable_q;
   logic                 summary_q;
   logic                 enabled_hit;
   logic                 all_clear;

   assign hit_slot  = wr_en_i && (wr_slot_i == MY_SLOT);
   assign wr_enable = hit_slot && (wr_sel_i == REG_ENABLE);
   assign wr_status = hit_slot && (wr_sel_i == REG_STATUS);

   // One storage cell per implemented event bit; unimplemented positions are tied off.
   for (genvar i = 0; i < EVT_W; i++) begin : g_bit
      if (EVT_MASK[i]) begin : g_live
         assign set_vec[i] = evt_i[i];
         if (i < W1C_W) begin : g_w1c
            assign clr_vec[i] = wr_status && wdata_i[i];
         end else begin : g_sticky
            assign clr_vec[i] = 1'b0;
         end
         // Set wins over clear on the same edge.
         assign stat_d[i] = set_vec[i] | (stat_q[i] & ~clr_vec[i]);
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               stat_q[i] <= 1'b0;
            end else begin
               stat_q[i] <= stat_d[i];
            end
         end
      end else begin : g_tied
         assign set_vec[i] = 1'b0;
         assign clr_vec[i] = 1'b0;
         assign stat_d[i]  = 1'b0;
         assign stat_q[i]  = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         enable_q <= '0;
      end else if (wr_enable) begin
         enable_q <= wdata_i[CTRL_W-1:0];
      end
   end

   assign enabled_hit = |(set_vec[CTRL_W-1:0] & enable_q);
   assign all_clear   = (stat_d == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         summary_q <= 1'b0;
      end else if (enabled_hit) begin
         summary_q <= 1'b1;
      end else if (wr_status && all_clear) begin
         summary_q <= 1'b0;
      end
   end

   always_comb begin
      status_word_o              = '0;
      status_word_o[EVT_W-1:0]   = stat_q;
      status_word_o[SEL_BIT]     = slv_sel_i;
      status_word_o[PEND_BIT]    = slv_pend_i;
   end

   assign enable_o  = enable_q;
   assign summary_o = summary_q;

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
   import irq_agg_pkg::*;
#(
   parameter int NUM_BUS = 4,
   parameter int SLOT_W  = 3
) (
   input  logic [SLOT_W:0]              addr_i,
   input  logic [NUM_BUS*CTRL_W-1:0]    enable_vec_i,
   input  logic [NUM_BUS*DATA_W-1:0]    status_vec_i,
   input  logic [NUM_BUS-1:0]           summary_i,
   output logic [DATA_W-1:0]            rdata_o
);

   localparam logic [SLOT_W-1:0] SUM_SLOT = {SLOT_W{1'b1}};

   logic [SLOT_W-1:0] slot;
   reg_sel_e          sel;

   assign slot = addr_i[SLOT_W:1];
   assign sel  = reg_sel_e'(addr_i[0]);

   always_comb begin
      rdata_o = '0;
      if (slot == SUM_SLOT && sel == REG_ENABLE) begin
         rdata_o[NUM_BUS-1:0] = summary_i;
      end
      for (int b = 0; b < NUM_BUS; b++) begin
         if (slot == SLOT_W'(b)) begin
            if (sel == REG_STATUS) begin
               rdata_o = status_vec_i[b*DATA_W +: DATA_W];
            end else begin
               rdata_o = {{(DATA_W-CTRL_W){1'b0}}, enable_vec_i[b*CTRL_W +: CTRL_W]};
            end
         end
      end
   end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int               NUM_BUS  = 4,
   parameter logic [EVT_W-1:0] EVT_MASK = 16'hE0FF,
   localparam int              SLOT_W   = $clog2(NUM_BUS + 1),
   localparam int              ADDR_W   = SLOT_W + 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [NUM_BUS*EVT_W-1:0] evt_i,
   input  logic [NUM_BUS-1:0]       slv_sel_i,
   input  logic [NUM_BUS-1:0]       slv_pend_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic                     irq_o
);

   if (NUM_BUS < 1 || NUM_BUS > 16) begin : g_bad_count
      $error("irq_aggregator: NUM_BUS must be within 1..16");
   end
   if (EVT_MASK[11:8] != 4'h0) begin : g_bad_mask
      $error("irq_aggregator: event bits 8..11 are not implementable");
   end

   logic [NUM_BUS*CTRL_W-1:0] enable_vec;
   logic [NUM_BUS*DATA_W-1:0] status_vec;
   logic [NUM_BUS-1:0]        summary_vec;
   logic [SLOT_W-1:0]         wr_slot;
   reg_sel_e                  wr_sel;

   assign wr_slot = addr_i[ADDR_W-1:1];
   assign wr_sel  = reg_sel_e'(addr_i[0]);

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      irq_bus_slice #(
         .BUS_ID   (b),
         .SLOT_W   (SLOT_W),
         .EVT_MASK (EVT_MASK)
      ) u_slice (
         .clk_i         (clk_i),
         .rst_ni        (rst_ni),
         .wr_en_i       (wr_en_i),
         .wr_slot_i     (wr_slot),
         .wr_sel_i      (wr_sel),
         .wdata_i       (wdata_i),
         .evt_i         (evt_i[b*EVT_W +: EVT_W]),
         .slv_sel_i     (slv_sel_i[b]),
         .slv_pend_i    (slv_pend_i[b]),
         .enable_o      (enable_vec[b*CTRL_W +: CTRL_W]),
         .status_word_o (status_vec[b*DATA_W +: DATA_W]),
         .summary_o     (summary_vec[b])
      );
   end

   irq_rd_mux #(
      .NUM_BUS (NUM_BUS),
      .SLOT_W  (SLOT_W)
   ) u_rd_mux (
      .addr_i       (addr_i),
      .enable_vec_i (enable_vec),
      .status_vec_i (status_vec),
      .summary_i    (summary_vec),
      .rdata_o      (rdata_o)
   );

   assign irq_o = |summary_vec;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int               NUM_BUS  = 4,
   parameter logic [EVT_W-1:0] EVT_MASK = 16'hE0FF,
   localparam int              SLOT_W   = $clog2(NUM_BUS + 1),
   localparam int              ADDR_W   = SLOT_W + 1
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      wr_en_i,
   input logic [ADDR_W-1:0]         addr_i,
   input logic [NUM_BUS*EVT_W-1:0]  evt_i,
   input logic [DATA_W-1:0]         rdata_o,
   input logic                      irq_o,
   input logic [NUM_BUS-1:0]        summary_vec,
   input logic [NUM_BUS*CTRL_W-1:0] enable_vec
);

   // R9: reserved status positions never carry data, whatever is read
   assert_reserved_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[19:16] == 4'h0);

   // R11: interrupt can only rise after some event pulse
   assert_irq_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(|evt_i));

   // R7: interrupt can only fall after a status write
   assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(wr_en_i && addr_i[0]));

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_chk
      // R5: an enabled event raises this bus's summary bit on the next edge
      assert_summary_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (|(evt_i[b*EVT_W +: CTRL_W] & EVT_MASK[CTRL_W-1:0] & enable_vec[b*CTRL_W +: CTRL_W]))
         |=> summary_vec[b]);

      // R7: a summary bit falls only after a status write to its own bus
      assert_summary_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(summary_vec[b]) |-> $past(wr_en_i && addr_i == ADDR_W'(2*b + 1)));
   end

endmodule

bind irq_aggregator irq_aggregator_chk #(
   .NUM_BUS  (NUM_BUS),
   .EVT_MASK (EVT_MASK)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .wr_en_i     (wr_en_i),
   .addr_i      (addr_i),
   .evt_i       (evt_i),
   .rdata_o     (rdata_o),
   .irq_o       (irq_o),
   .summary_vec (summary_vec),
   .enable_vec  (enable_vec)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 4;
   localparam int AW         = 4;
   localparam logic [AW-1:0] A_SUM = 4'd14;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [31:0]      wdata = '0;
   logic [NB*16-1:0] evt = '0;
   logic [NB-1:0]    slv_sel = '0;
   logic [NB-1:0]    slv_pend = '0;
   logic [31:0]      rdata;
   logic             irq;

   int n_run  = 0;
   int n_fail = 0;
   item_t sb_q[$];
   event  smp_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_aggregator #(.NUM_BUS(NB)) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_en_i    (wr_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .evt_i      (evt),
      .slv_sel_i  (slv_sel),
      .slv_pend_i (slv_pend),
      .rdata_o    (rdata),
      .irq_o      (irq)
   );

   function automatic logic [AW-1:0] a_en(int b);
      return AW'(2*b);
   endfunction
   function automatic logic [AW-1:0] a_st(int b);
      return AW'(2*b + 1);
   endfunction

   // Monitor: pops expected items and compares against the design
   always @(smp_ev) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'b0, irq} : rdata;
         n_run++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
         end
      end
   end

   task automatic expect_rd(input logic [AW-1:0] a, input logic [31:0] e, input string req);
      item_t it;
      @(negedge clk);
      addr  = a;
      wr_en = 1'b0;
      it.is_irq = 1'b0; it.exp = e; it.req = req;
      sb_q.push_back(it);
      #1 -> smp_ev;
      #1;
   endtask

   task automatic expect_irq(input logic e, input string req);
      item_t it;
      @(negedge clk);
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = req;
      sb_q.push_back(it);
      #1 -> smp_ev;
      #1;
   endtask

   task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [NB*16-1:0] v);
      @(negedge clk);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic pulse_and_wr(input logic [NB*16-1:0] v, input logic [AW-1:0] a,
                               input logic [31:0] d);
      @(negedge clk);
      evt = v; addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      evt = '0; wr_en = 1'b0;
   endtask

   function automatic logic [NB*16-1:0] ev(int b, logic [15:0] bits);
      logic [NB*16-1:0] v = '0;
      v[b*16 +: 16] = bits;
      return v;
   endfunction

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      expect_rd(a_st(0), 32'h0, "R1 status0");
      expect_rd(a_en(0), 32'h0, "R1 enable0");
      expect_rd(A_SUM, 32'h0, "R1 summary");
      expect_irq(1'b0, "R1 irq");

      // R3: enable keeps [14:0] only
      reg_wr(a_en(0), 32'hFFFF_FFFF);
      expect_rd(a_en(0), 32'h0000_7FFF, "R3 enable width");

      // R2 / R10: all bits pulsed on disabled bus 1
      pulse(ev(1, 16'hFFFF));
      expect_rd(a_st(1), 32'h0000_E0FF, "R2 implemented bits");
      expect_rd(A_SUM, 32'h0, "R10 no summary");
      expect_irq(1'b0, "R10 irq low");
      // R4: bit 15 not clearable
      reg_wr(a_st(1), 32'hFFFF_FFFF);
      expect_rd(a_st(1), 32'h0000_8000, "R4 bit15 sticky");

      // R5: enabled event on bus 0
      pulse(ev(0, 16'h0004));
      expect_rd(a_st(0), 32'h0000_0004, "R2 rx done set");
      expect_rd(A_SUM, 32'h1, "R5 summary set");
      expect_irq(1'b1, "R5 irq high");
      pulse(ev(0, 16'h0008));
      // R6: partial clear keeps summary
      reg_wr(a_st(0), 32'h0000_0004);
      expect_rd(a_st(0), 32'h0000_0008, "R4 partial clear");
      expect_rd(A_SUM, 32'h1, "R6 summary held");
      expect_irq(1'b1, "R6 irq held");
      reg_wr(a_st(0), 32'h0);
      expect_rd(a_st(0), 32'h0000_0008, "R4 zero write no effect");
      // R7: full clear
      reg_wr(a_st(0), 32'h0000_0008);
      expect_rd(a_st(0), 32'h0, "R7 status clear");
      expect_rd(A_SUM, 32'h0, "R7 summary clear");
      expect_irq(1'b0, "R7 irq low");

      // R11: two buses
      reg_wr(a_en(2), 32'h1);
      pulse(ev(0, 16'h0001) | ev(2, 16'h0001));
      expect_rd(A_SUM, 32'h5, "R11 summary two buses");
      reg_wr(a_st(0), 32'h1);
      expect_rd(A_SUM, 32'h4, "R11 summary one left");
      expect_irq(1'b1, "R11 irq still high");
      reg_wr(a_st(2), 32'h1);
      expect_irq(1'b0, "R11 irq low");

      // R8: set beats clear
      pulse(ev(0, 16'h0002));
      pulse_and_wr(ev(0, 16'h0002), a_st(0), 32'h0000_0002);
      expect_rd(a_st(0), 32'h0000_0002, "R8 set wins");
      expect_irq(1'b1, "R8 irq held");
      reg_wr(a_st(0), 32'h0000_0002);
      expect_irq(1'b0, "R8 cleared after");

      // R9: slave level bits, excluded from all-clear
      slv_sel[3] = 1'b1; slv_pend[3] = 1'b1;
      expect_rd(a_st(3), 32'hC000_0000, "R9 slave bits");
      reg_wr(a_en(3), 32'h1);
      pulse(ev(3, 16'h0001));
      expect_rd(A_SUM, 32'h8, "R9 summary bus3");
      reg_wr(a_st(3), 32'hFFFF_FFFF);
      expect_rd(a_st(3), 32'hC000_0000, "R9 slave bits live");
      expect_rd(A_SUM, 32'h0, "R9 all-clear ignores 31/30");
      slv_sel[3] = 1'b0;
      expect_rd(a_st(3), 32'h4000_0000, "R9 select follows input");

      // R12: out-of-map accesses
      reg_wr(4'd9, 32'hFFFF_FFFF);
      expect_rd(4'd9, 32'h0, "R12 unused slot");
      expect_rd(4'd15, 32'h0, "R12 summary select 1");
      expect_rd(a_en(0), 32'h0000_7FFF, "R12 no side effect");

      // R6 / R7: stuck bit 15 on bus 1 holds summary
      reg_wr(a_en(1), 32'h4);
      pulse(ev(1, 16'h0004));
      reg_wr(a_st(1), 32'h0000_0004);
      expect_rd(a_st(1), 32'h0000_8000, "R6 stuck bit remains");
      expect_rd(A_SUM, 32'h2, "R7 summary kept by bit15");
      expect_irq(1'b1, "R6 irq kept");

      @(negedge clk);
      if (sb_q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule